// File: doc/BRIEF.md
# Vector Compare-Select Unit

This unit works on eight lanes of signed 16-bit data at once. On each accepted request it runs one of five lane-parallel operations: a less-than test, a greater-or-equal test, an equality test, an inequality test, or a merge. Each operation forms one compare bit per lane and picks a 16-bit result per lane from the two source vectors. The compare bit also feeds a per-lane flag file.

The flag file holds five 8-bit registers with one bit per lane: not-equal, carry, clip, compare and extended-compare. The not-equal and carry flags left by earlier operations change how an equal pair of operands is treated. The merge operation selects lanes using the stored compare flags. The selected vector goes to the destination output and to a low-accumulator output. Both are registered.

A flag write port loads all five flag registers directly. This lets the surrounding logic, or a test, set up any flag state before an operation. Opcode decode, register-file access and element broadcast are handled elsewhere.

Top module: `vcmp_select_unit`

## Requirements
- R1: Opcode 0 (less-than): per lane, compare = (S < T, signed) or (S == T and not-equal flag and carry flag). The result lane is S when compare is 1 and T otherwise.
- R2: Opcode 3 (greater-or-equal): per lane, compare = (S > T, signed) or (S == T and not both not-equal flag and carry flag). The result lane is S when compare is 1 and T otherwise.
- R3: Opcode 1 (equal): per lane, compare = (S == T) and not the not-equal flag. The result is always T.
- R4: Opcode 2 (not-equal): per lane, compare = (S != T) or the not-equal flag. The result is always S.
- R5: Opcode 4 (merge): each result lane is S where the stored compare flag of that lane is 1 and T elsewhere. All five flag registers keep their values.
- R6: After opcodes 0 to 3, the not-equal, carry and clip flags of every lane read 0. The compare flag holds the new compare bits, and the extended-compare flag is unchanged.
- R7: The result and the low-accumulator output carry the same value. Both update on the clock edge that accepts a valid request and hold at all other times. Lane i occupies bits [16i+15:16i], and flag bit i belongs to lane i.
- R8: A valid request with a reserved opcode (5, 6 or 7) changes neither the outputs nor any flag.
- R9: When the flag write strobe is high, all five flag registers take the written values on the next edge. A valid request in the same cycle is dropped, so the result outputs hold.
- R10: Synchronous reset clears the result, the low-accumulator output and all five flag registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| src_s_i | input | 128 | Source vector S, eight signed 16-bit lanes |
| src_t_i | input | 128 | Source vector T, eight signed 16-bit lanes |
| flag_wr_i | input | 1 | Load all flag registers |
| wr_ne_i | input | 8 | Not-equal flag load value |
| wr_co_i | input | 8 | Carry flag load value |
| wr_clip_i | input | 8 | Clip flag load value |
| wr_comp_i | input | 8 | Compare flag load value |
| wr_vce_i | input | 8 | Extended-compare flag load value |
| result_o | output | 128 | Destination result vector |
| acc_lo_o | output | 128 | Low-accumulator copy of the result |
| ne_o | output | 8 | Not-equal flags |
| co_o | output | 8 | Carry flags |
| clip_o | output | 8 | Clip flags |
| comp_o | output | 8 | Compare flags |
| vce_o | output | 8 | Extended-compare flags |

## Verification
The bench sweeps every ordered pair drawn from a set of eight values. The set includes -32768, -1, 0, 1 and 32767, so a design that compares unsigned would give the wrong answer on lanes with mixed signs. In every sweep block one lane holds equal operands, and the sweep rotates that lane through all eight not-equal, carry and compare flag combinations. A design that mishandles the tie rule for less-than or greater-or-equal therefore returns the wrong source. The same sweep catches an equality or inequality test that ignores the not-equal flag, and a merge that rewrites flags or keys on the wrong flag. Separate cases catch a reserved opcode that leaks into the outputs, a flag write that fails to win over a same-cycle request, and an extended-compare flag that gets cleared.

// File: rtl/vcs_pkg.sv
package vcs_pkg;

    localparam int VCS_LANES = 8;
    localparam int VCS_EW    = 16;

    typedef enum logic [2:0] {
        OP_LT  = 3'd0,
        OP_EQ  = 3'd1,
        OP_NE  = 3'd2,
        OP_GE  = 3'd3,
        OP_MRG = 3'd4
    } vcs_op_e;

    // Lane-level decision: compare bit plus the chosen element
    typedef struct packed {
        logic               cmp;
        logic [VCS_EW-1:0]  val;
    } vcs_lane_out_t;

    function automatic logic op_is_test(input logic [2:0] op);
        return op <= 3'd3;
    endfunction

    function automatic logic op_is_legal(input logic [2:0] op);
        return op <= 3'd4;
    endfunction

endpackage

// File: rtl/vcs_lane.sv
module vcs_lane
    import vcs_pkg::*;
(
    input  logic [2:0]              op,
    input  logic signed [VCS_EW-1:0] s,
    input  logic signed [VCS_EW-1:0] t,
    input  logic                    ne_f,
    input  logic                    co_f,
    input  logic                    comp_f,
    output vcs_lane_out_t           out
);
    logic same, s_lt, s_gt, tie_low;

    always_comb begin
        same    = (s == t);
        s_lt    = (s < t);
        s_gt    = (s > t);
        tie_low = ne_f & co_f;
        out.cmp = comp_f;
        out.val = t;
        case (op)
            OP_LT: begin
                out.cmp = s_lt | (same & tie_low);
                out.val = out.cmp ? s : t;
            end
            OP_GE: begin
                out.cmp = s_gt | (same & ~tie_low);
                out.val = out.cmp ? s : t;
            end
            OP_EQ: begin
                out.cmp = same & ~ne_f;
                out.val = t;
            end
            OP_NE: begin
                out.cmp = ~same | ne_f;
                out.val = s;
            end
            OP_MRG: begin
                out.cmp = comp_f;
                out.val = comp_f ? s : t;
            end
            default: begin
                out.cmp = comp_f;
                out.val = t;
            end
        endcase
    end
endmodule

// File: rtl/vcs_flag_file.sv
module vcs_flag_file #(
    parameter int LANES = vcs_pkg::VCS_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_ne,
    input  logic [LANES-1:0] wr_co,
    input  logic [LANES-1:0] wr_clip,
    input  logic [LANES-1:0] wr_comp,
    input  logic [LANES-1:0] wr_vce,
    input  logic             upd_en,
    input  logic [LANES-1:0] new_comp,
    output logic [LANES-1:0] ne_q,
    output logic [LANES-1:0] co_q,
    output logic [LANES-1:0] clip_q,
    output logic [LANES-1:0] comp_q,
    output logic [LANES-1:0] vce_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ne_q   <= '0;
            co_q   <= '0;
            clip_q <= '0;
            comp_q <= '0;
            vce_q  <= '0;
        end else if (wr_en) begin
            ne_q   <= wr_ne;
            co_q   <= wr_co;
            clip_q <= wr_clip;
            comp_q <= wr_comp;
            vce_q  <= wr_vce;
        end else if (upd_en) begin
            ne_q   <= '0;
            co_q   <= '0;
            clip_q <= '0;
            comp_q <= new_comp;
        end
    end

    assert_flags_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !wr_en) |=> (ne_q == '0 && co_q == '0 && clip_q == '0));

    assert_comp_written_R6: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !wr_en) |=> (comp_q == $past(new_comp)));

    assert_vce_kept_R6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(vce_q));

    assert_load_all_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ne_q == $past(wr_ne) && comp_q == $past(wr_comp) && vce_q == $past(wr_vce)));

    assert_reset_zero_R10: assert property (@(posedge clk)
        rst |=> (ne_q == '0 && co_q == '0 && clip_q == '0 && comp_q == '0 && vce_q == '0));
endmodule

// File: rtl/vcs_result_reg.sv
module vcs_result_reg #(
    parameter int WIDTH = vcs_pkg::VCS_LANES * vcs_pkg::VCS_EW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/vcmp_select_unit.sv
module vcmp_select_unit
    import vcs_pkg::*;
#(
    parameter int LANES = VCS_LANES,
    parameter int EW    = VCS_EW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [2:0]          op_i,
    input  logic [LANES*EW-1:0] src_s_i,
    input  logic [LANES*EW-1:0] src_t_i,
    input  logic                flag_wr_i,
    input  logic [LANES-1:0]    wr_ne_i,
    input  logic [LANES-1:0]    wr_co_i,
    input  logic [LANES-1:0]    wr_clip_i,
    input  logic [LANES-1:0]    wr_comp_i,
    input  logic [LANES-1:0]    wr_vce_i,
    output logic [LANES*EW-1:0] result_o,
    output logic [LANES*EW-1:0] acc_lo_o,
    output logic [LANES-1:0]    ne_o,
    output logic [LANES-1:0]    co_o,
    output logic [LANES-1:0]    clip_o,
    output logic [LANES-1:0]    comp_o,
    output logic [LANES-1:0]    vce_o
);
    localparam int VW = LANES * EW;

    logic             fire, upd;
    logic [LANES-1:0] cmp_vec;
    logic [VW-1:0]    sel_vec;

    // A flag load takes the cycle; legal requests only otherwise
    assign fire = valid_i && !flag_wr_i && op_is_legal(op_i);
    assign upd  = fire && op_is_test(op_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vcs_lane_out_t lo;
        vcs_lane u_lane (
            .op     (op_i),
            .s      (src_s_i[g*EW +: EW]),
            .t      (src_t_i[g*EW +: EW]),
            .ne_f   (ne_o[g]),
            .co_f   (co_o[g]),
            .comp_f (comp_o[g]),
            .out    (lo)
        );
        assign cmp_vec[g]         = lo.cmp;
        assign sel_vec[g*EW +: EW] = lo.val;
    end

    vcs_flag_file #(.LANES(LANES)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (flag_wr_i),
        .wr_ne    (wr_ne_i),
        .wr_co    (wr_co_i),
        .wr_clip  (wr_clip_i),
        .wr_comp  (wr_comp_i),
        .wr_vce   (wr_vce_i),
        .upd_en   (upd),
        .new_comp (cmp_vec),
        .ne_q     (ne_o),
        .co_q     (co_o),
        .clip_q   (clip_o),
        .comp_q   (comp_o),
        .vce_q    (vce_o)
    );

    vcs_result_reg #(.WIDTH(VW)) u_dest (
        .clk (clk), .rst (rst), .load (fire), .d (sel_vec), .q (result_o)
    );

    vcs_result_reg #(.WIDTH(VW)) u_acc (
        .clk (clk), .rst (rst), .load (fire), .d (sel_vec), .q (acc_lo_o)
    );

    assert_eq_takes_t_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !flag_wr_i && op_i == 3'd1) |=> (result_o == $past(src_t_i)));

    assert_ne_takes_s_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !flag_wr_i && op_i == 3'd2) |=> (result_o == $past(src_s_i)));

    assert_merge_keeps_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !flag_wr_i && op_i == 3'd4) |=>
        ($stable(ne_o) && $stable(co_o) && $stable(clip_o) && $stable(comp_o) && $stable(vce_o)));

    assert_acc_mirror_R7: assert property (@(posedge clk) disable iff (rst)
        result_o == acc_lo_o);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(result_o));

    assert_reserved_inert_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i > 3'd4) |=> ($stable(result_o) && $stable(comp_o)));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        flag_wr_i |=> $stable(result_o));
endmodule

// File: tb/sim_vcmp_select_unit.sv
module sim_vcmp_select_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int EW = 16;
    localparam int VW = LANES * EW;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid_i = 1'b0;
    logic [2:0] op_i = '0;
    logic [VW-1:0] src_s_i = '0, src_t_i = '0;
    logic flag_wr_i = 1'b0;
    logic [LANES-1:0] wr_ne_i = '0, wr_co_i = '0, wr_clip_i = '0, wr_comp_i = '0, wr_vce_i = '0;
    logic [VW-1:0] result_o, acc_lo_o;
    logic [LANES-1:0] ne_o, co_o, clip_o, comp_o, vce_o;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcmp_select_unit u0 (.*);

    task automatic check(input string req, input string what,
                         input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_flags(input string req, input logic [LANES-1:0] ne, co, clip, comp, vce);
        check(req, "flags", {88'd0, ne_o, co_o, clip_o, comp_o, vce_o},
              {88'd0, ne, co, clip, comp, vce});
    endtask

    function automatic logic signed [15:0] pick(input int k);
        case (k)
            0: return -16'sd32768;
            1: return -16'sd1;
            2: return 16'sd0;
            3: return 16'sd1;
            4: return 16'sd32767;
            5: return -16'sd2;
            6: return 16'sd100;
            default: return -16'sd100;
        endcase
    endfunction

    // Expected lane behaviour written from the requirement text
    function automatic logic [16:0] model(input int op, input logic signed [15:0] s,
                                          input logic signed [15:0] t,
                                          input logic ne, co, comp);
        logic c;
        logic [15:0] r;
        case (op)
            0: begin c = (s < t) || (s == t && ne && co);     r = c ? s : t; end  // R1
            3: begin c = (s > t) || (s == t && !(ne && co));  r = c ? s : t; end  // R2
            1: begin c = (s == t) && !ne;                     r = t;         end  // R3
            2: begin c = (s != t) || ne;                      r = s;         end  // R4
            default: begin c = comp;                          r = comp ? s : t; end // R5
        endcase
        return {c, r};
    endfunction

    task automatic load_flags(input logic [LANES-1:0] ne, co, clip, comp, vce);
        @(negedge clk);
        flag_wr_i = 1'b1;
        wr_ne_i = ne; wr_co_i = co; wr_clip_i = clip; wr_comp_i = comp; wr_vce_i = vce;
        @(negedge clk);
        flag_wr_i = 1'b0;
    endtask

    task automatic issue(input int op, input logic [VW-1:0] s, input logic [VW-1:0] t);
        @(negedge clk);
        valid_i = 1'b1; op_i = op[2:0]; src_s_i = s; src_t_i = t;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] s_v, t_v, exp_r, last_r;
        logic [LANES-1:0] ne_v, co_v, clip_v, comp_v, vce_v, exp_c;
        string tag;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        check("R10", "result", result_o, '0);
        check("R10", "acc", acc_lo_o, '0);
        check_flags("R10", '0, '0, '0, '0, '0);

        for (int op = 0; op < 5; op++) begin
            case (op)
                0: tag = "R1";
                1: tag = "R3";
                2: tag = "R4";
                3: tag = "R2";
                default: tag = "R5";
            endcase
            for (int fp = 0; fp < 8; fp++) begin
                for (int j = 0; j < 8; j++) begin
                    for (int l = 0; l < LANES; l++) begin
                        int code;
                        logic [16:0] m;
                        code = (fp + l) % 8;
                        ne_v[l] = code[0]; co_v[l] = code[1]; comp_v[l] = code[2];
                        clip_v[l] = ~code[0];
                        s_v[l*EW +: EW] = pick(j);
                        t_v[l*EW +: EW] = pick(l);
                        m = model(op, pick(j), pick(l), code[0], code[1], code[2]);
                        exp_c[l] = m[16];
                        exp_r[l*EW +: EW] = m[15:0];
                    end
                    vce_v = 8'hA5 ^ 8'(fp * 17 + j);
                    load_flags(ne_v, co_v, clip_v, comp_v, vce_v);
                    issue(op, s_v, t_v);
                    check(tag, "result", result_o, exp_r);
                    check("R7", "acc_lo", acc_lo_o, exp_r);
                    if (op == 4) check_flags("R5", ne_v, co_v, clip_v, comp_v, vce_v);
                    else         check_flags("R6", '0, '0, '0, exp_c, vce_v);
                end
            end
        end

        // R7: outputs hold while idle
        last_r = result_o;
        repeat (3) @(negedge clk);
        check("R7", "idle hold", result_o, last_r);
        check("R7", "idle hold acc", acc_lo_o, last_r);

        // R8: reserved opcodes leave everything untouched
        load_flags(8'h3C, 8'hC3, 8'h5A, 8'h96, 8'h0F);
        for (int op = 5; op < 8; op++) begin
            issue(op, {8{16'h1234}}, {8{16'h8765}});
            check("R8", "result", result_o, last_r);
            check("R8", "acc", acc_lo_o, last_r);
            check_flags("R8", 8'h3C, 8'hC3, 8'h5A, 8'h96, 8'h0F);
        end

        // R9: flag load beats a same-cycle request
        @(negedge clk);
        valid_i = 1'b1; op_i = 3'd2; src_s_i = {8{16'h7777}}; src_t_i = {8{16'h1111}};
        flag_wr_i = 1'b1;
        wr_ne_i = 8'h81; wr_co_i = 8'h42; wr_clip_i = 8'h24; wr_comp_i = 8'h18; wr_vce_i = 8'hFF;
        @(negedge clk);
        valid_i = 1'b0; flag_wr_i = 1'b0;
        check("R9", "result", result_o, last_r);
        check_flags("R9", 8'h81, 8'h42, 8'h24, 8'h18, 8'hFF);

        // R10: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R10", "result", result_o, '0);
        check("R10", "acc", acc_lo_o, '0);
        check_flags("R10", '0, '0, '0, '0, '0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule